// File: doc/BRIEF.md
# Multi-plane page program sequencer

This block is the host-side engine that writes up to four NAND pages in a single program operation. The device has eight planes in two groups of four. The requester names one group and any non-empty subset of its four planes. The sequencer then visits the selected planes in ascending order. For each plane it sends the serial-input command and a column-plus-row address, then forwards exactly 528 bytes taken from a valid/ready byte stream. Every plane except the last is closed with the dummy program command; the last is closed with the true program command. After each close the sequencer polls status until the device is ready again. When programming ends it reads the multi-plane status byte and returns a fail flag for each plane plus an overall fail flag.

The flash bus is abstracted as one transfer per cycle. `bus_valid` qualifies a transfer and `bus_kind` says what it is. For writes the byte is on `bus_wdata`. For reads the device answers combinationally on `bus_rdata` in the same cycle. Two kinds of request are refused without any bus transfer: a request whose plane mask is all zero, and a request made while the device column pointer is in the alternate mode.

Top module: `mpp_seq`

## Requirements
- R1: A start with `plane_mask` equal to 0 makes no bus transfer. On the clock edge after the start, `done` and `err` go high for one cycle.
- R2: A start while `alt_ptr` is high is refused in the same way as R1 (`done` and `err` high for one cycle, no bus transfer).
- R3: Selected planes are loaded in ascending index order, and unselected planes are skipped. Each load begins with command 0x80 (kind 0) followed by three address transfers (kind 1). These are 0x00, then the low byte and then the high byte of the 16-bit row {page_row[12:0], group_sel, plane index[1:0]}.
- R4: Per plane exactly 528 stream bytes are accepted. Each is forwarded unchanged as a data write (kind 2) in the cycle it is accepted. `s_ready` is low outside the data phase.
- R5: Every plane except the last is closed with command 0x11, and the last is closed with command 0x10.
- R6: Each closing command is followed directly by command 0x70. The sequencer then makes status reads (kind 3) until bit 6 of `bus_rdata` is 1. No other command is sent while the device reports busy.
- R7: Once ready follows the 0x10 close, command 0x71 is sent and one status byte is read. On the next edge `done` pulses for one cycle with `err` low. `fail_vec[i]` is status bit i+1 ANDed with the mask, and `fail_any` is status bit 0.
- R8: A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| plane_mask | input | 4 | Planes of the chosen group to program |
| group_sel | input | 1 | 0 selects planes 0-3, 1 selects planes 4-7 |
| page_row | input | 13 | Page row above the plane bits |
| alt_ptr | input | 1 | Device column pointer is in the alternate mode |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| bus_valid | output | 1 | Bus transfer this cycle |
| bus_kind | output | 2 | 0 command, 1 address, 2 data write, 3 status read |
| bus_wdata | output | 8 | Command, address or data byte |
| bus_rdata | input | 8 | Status byte returned in a read cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with done |
| fail_vec | output | 4 | Per-plane fail flags, masked |
| fail_any | output | 1 | Overall fail flag from status bit 0 |

## Verification
Bus transfers are combinational from the sequencer state and the stream inputs, so every transfer is observed in the cycle it occurs. The monitor samples just after the falling edge, once the driver has set that cycle's stream inputs. A refused request shows `done` and `err` at the first falling edge after the start edge. A completed operation shows `done` one cycle after the 0x71 status read, and the bench samples result ports only at that falling edge. The number of busy polls depends on the device model, so the scoreboard skips reads and 0x70 commands. A separate check confirms that no other command appears while the model is busy.

// File: rtl/mpp_pkg.sv
// Shared types and command codes for the multi-plane program sequencer.
// Assumes one bus transfer per cycle with a two-bit transfer kind.
package mpp_pkg;
    typedef enum logic [1:0] {
        BK_CMD  = 2'd0,
        BK_ADDR = 2'd1,
        BK_WR   = 2'd2,
        BK_RD   = 2'd3
    } bus_kind_t;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_ADDR, S_DATA, S_CLOSE,
        S_PCMD, S_PRD, S_MCMD, S_MRD
    } seq_state_t;

    localparam logic [7:0] CMD_SERIAL_IN = 8'h80;
    localparam logic [7:0] CMD_DUMMY_PGM = 8'h11;
    localparam logic [7:0] CMD_TRUE_PGM  = 8'h10;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] CMD_MP_STATUS = 8'h71;
    localparam int         READY_BIT     = 6;
endpackage

// File: rtl/mpp_plane_pick.sv
// Picks the lowest plane still pending in a mask and reports whether it
// is the final one. Purely combinational; assumes NPL >= 2.
module mpp_plane_pick #(
    parameter int NPL   = 4,
    localparam int IDX_W = $clog2(NPL)
) (
    input  logic [NPL-1:0]   pending,
    output logic [IDX_W-1:0] idx,
    output logic [NPL-1:0]   onehot,
    output logic             is_last
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = NPL - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx    = IDX_W'(i);
                onehot = NPL'(1) << i;
            end
        end
        is_last = (pending & ~onehot) == '0;
    end
endmodule

// File: rtl/mpp_byte_ctr.sv
// Counts accepted page bytes and flags the final byte of a page.
// Wraps to zero on that byte, so it is ready for the next plane.
module mpp_byte_ctr #(
    parameter int PAGE_BYTES = 528,
    localparam int CNT_W     = $clog2(PAGE_BYTES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic last
);
    logic [CNT_W-1:0] cnt;

    assign last = (cnt == CNT_W'(PAGE_BYTES - 1));

    // Advance on each accepted byte, wrap after the page.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (inc)    cnt <= last ? '0 : cnt + 1'b1;
    end

    a_r4_cnt_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(PAGE_BYTES));
endmodule

// File: rtl/mpp_seq.sv
// Multi-plane page program sequencer: loads each selected plane of one
// group, separates the loads with dummy program commands, commits with
// the true program command and returns masked per-plane fail flags.
// Assumes the device answers a read combinationally in the read cycle.
module mpp_seq #(
    parameter int PAGE_BYTES = 528,
    parameter int NPL        = 4,
    parameter int ROW_W      = 16,
    localparam int IDX_W     = $clog2(NPL),
    localparam int PROW_W    = ROW_W - 1 - IDX_W,
    localparam int ADDR_CYC  = 1 + ROW_W / 8,
    localparam int ACNT_W    = $clog2(ADDR_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPL-1:0]    plane_mask,
    input  logic              group_sel,
    input  logic [PROW_W-1:0] page_row,
    input  logic              alt_ptr,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    output logic              s_ready,
    output logic              bus_valid,
    output logic [1:0]        bus_kind,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              done,
    output logic              err,
    output logic [NPL-1:0]    fail_vec,
    output logic              fail_any
);
    import mpp_pkg::*;

    seq_state_t        state;
    logic [NPL-1:0]    mask_q, pend_q;
    logic              grp_q, fin_q;
    logic [PROW_W-1:0] prow_q;
    logic [ACNT_W-1:0] acnt;
    logic [IDX_W-1:0]  cur_idx;
    logic [NPL-1:0]    cur_oh;
    logic              cur_last, page_end, take;
    logic [ROW_W-1:0]  row;
    logic              unused_rd;

    assign unused_rd = ^{bus_rdata[7], bus_rdata[5]};

    mpp_plane_pick #(.NPL(NPL)) i_pick (
        .pending(pend_q), .idx(cur_idx), .onehot(cur_oh), .is_last(cur_last)
    );

    assign take = (state == S_DATA) && s_valid;

    mpp_byte_ctr #(.PAGE_BYTES(PAGE_BYTES)) i_ctr (
        .clk(clk), .rst_n(rst_n), .inc(take), .last(page_end)
    );

    assign row = {prow_q, grp_q, cur_idx};

    // Drive the bus transfer implied by the current state.
    always_comb begin
        bus_valid = 1'b0;
        bus_kind  = BK_CMD;
        bus_wdata = 8'h00;
        s_ready   = 1'b0;
        case (state)
            S_LOAD:  begin bus_valid = 1'b1; bus_wdata = CMD_SERIAL_IN; end
            S_ADDR:  begin
                bus_valid = 1'b1;
                bus_kind  = BK_ADDR;
                bus_wdata = (acnt == '0) ? 8'h00
                                         : row[8*(int'(acnt)-1) +: 8];
            end
            S_DATA:  begin
                s_ready   = 1'b1;
                bus_valid = s_valid;
                bus_kind  = BK_WR;
                bus_wdata = s_data;
            end
            S_CLOSE: begin
                bus_valid = 1'b1;
                bus_wdata = cur_last ? CMD_TRUE_PGM : CMD_DUMMY_PGM;
            end
            S_PCMD:  begin bus_valid = 1'b1; bus_wdata = CMD_STATUS; end
            S_MCMD:  begin bus_valid = 1'b1; bus_wdata = CMD_MP_STATUS; end
            S_PRD, S_MRD: begin bus_valid = 1'b1; bus_kind = BK_RD; end
            default: ;
        endcase
    end

    // Sequence the planes, the closing commands, polling and status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            mask_q   <= '0;
            pend_q   <= '0;
            grp_q    <= 1'b0;
            fin_q    <= 1'b0;
            prow_q   <= '0;
            acnt     <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            fail_vec <= '0;
            fail_any <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    done <= 1'b0;
                    err  <= 1'b0;
                    if (start) begin
                        if (plane_mask == '0 || alt_ptr) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            mask_q   <= plane_mask;
                            pend_q   <= plane_mask;
                            grp_q    <= group_sel;
                            prow_q   <= page_row;
                            fail_vec <= '0;
                            fail_any <= 1'b0;
                            state    <= S_LOAD;
                        end
                    end
                end
                S_LOAD: begin
                    acnt  <= '0;
                    state <= S_ADDR;
                end
                S_ADDR: begin
                    acnt <= acnt + 1'b1;
                    if (acnt == ACNT_W'(ADDR_CYC - 1)) state <= S_DATA;
                end
                S_DATA: if (take && page_end) state <= S_CLOSE;
                S_CLOSE: begin
                    fin_q  <= cur_last;
                    pend_q <= pend_q & ~cur_oh;
                    state  <= S_PCMD;
                end
                S_PCMD: state <= S_PRD;
                S_PRD:  if (bus_rdata[READY_BIT]) state <= fin_q ? S_MCMD : S_LOAD;
                S_MCMD: state <= S_MRD;
                S_MRD: begin
                    fail_vec <= bus_rdata[NPL:1] & mask_q;
                    fail_any <= bus_rdata[0];
                    done     <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r1_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && (plane_mask == '0 || alt_ptr))
        |=> (done && err && !bus_valid));

    a_r3_plane_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD) |-> ((cur_oh & mask_q) != '0));

    a_r6_poll_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == BK_CMD &&
         (bus_wdata == CMD_DUMMY_PGM || bus_wdata == CMD_TRUE_PGM))
        |=> (bus_valid && bus_kind == BK_CMD && bus_wdata == CMD_STATUS));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_fail_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((fail_vec & ~mask_q) == '0));
endmodule

// File: tb/test_mpp_seq.sv
// Scoreboard bench: the driver queues the expected bus transfers, the
// monitor pops and compares them, and a busy device model answers polls.
module test_mpp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE       = 528;
    localparam int DBSY       = 5;
    localparam int PROG       = 40;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start = 1'b0, group_sel = 1'b0, alt_ptr = 1'b0;
    logic [3:0]  plane_mask = '0;
    logic [12:0] page_row = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready, bus_valid, done, err, fail_any;
    logic [1:0]  bus_kind;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [3:0]  fail_vec;

    int checks = 0, fails = 0;
    logic [9:0] expq[$];
    int   busy = 0, busy_polls = 0;
    logic [7:0] last_cmd = 8'h00;
    logic [4:0] stat_pat = '0;
    logic [7:0] seed = 8'h00;

    mpp_seq i_mpp_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .plane_mask(plane_mask),
        .group_sel(group_sel), .page_row(page_row), .alt_ptr(alt_ptr),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .done(done), .err(err),
        .fail_vec(fail_vec), .fail_any(fail_any)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Device model: status answers ready per busy timer, 0x71 gives results.
    assign bus_rdata = (last_cmd == 8'h71)
        ? {1'b1, (busy == 0), 1'b0, stat_pat}
        : {1'b0, (busy == 0), 6'b0};

    always @(posedge clk) begin
        if (busy > 0) busy <= busy - 1;
        if (bus_valid && bus_kind == 2'd0) begin
            last_cmd <= bus_wdata;
            if (bus_wdata == 8'h11) busy <= DBSY;
            if (bus_wdata == 8'h10) busy <= PROG;
        end
        if (bus_valid && bus_kind == 2'd3 && busy != 0) busy_polls <= busy_polls + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each non-poll transfer against the queue.
    always @(negedge clk) begin
        #1;
        if (rst_n && bus_valid) begin
            if (bus_kind == 2'd0 && bus_wdata != 8'h70 && busy != 0)
                check(1'b0, "R6 command while busy", {bus_kind, bus_wdata}, 0);
            if (!(bus_kind == 2'd3 || (bus_kind == 2'd0 && bus_wdata == 8'h70))) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R1/R2/R8 unexpected transfer", {bus_kind, bus_wdata}, 0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    check({bus_kind, bus_wdata} == e, "R3/R4/R5 bus order",
                          {bus_kind, bus_wdata}, e);
                end
            end
        end
    end

    function automatic logic [7:0] dbyte(input int i);
        return 8'(i * 7) + seed;
    endfunction

    // Driver: queue expected transfers, start the request and stream bytes.
    task automatic run_op(input logic [3:0] m, input logic g, input logic [12:0] pr,
                          input logic [4:0] pat, input bit poke);
        int total = 0, bi = 0, nsel = 0, cyc = 0;
        int polls0;
        logic [15:0] row;
        for (int p = 0; p < 4; p++) if (m[p]) nsel++;
        for (int p = 0; p < 4; p++) begin
            if (m[p]) begin
                row = {pr, g, 2'(p)};
                expq.push_back({2'd0, 8'h80});
                expq.push_back({2'd1, 8'h00});
                expq.push_back({2'd1, row[7:0]});
                expq.push_back({2'd1, row[15:8]});
                for (int k = 0; k < PAGE; k++) expq.push_back({2'd2, dbyte(total + k)});
                total += PAGE;
                expq.push_back({2'd0, (total == nsel * PAGE) ? 8'h10 : 8'h11});
            end
        end
        expq.push_back({2'd0, 8'h71});
        stat_pat = pat;
        polls0 = busy_polls;
        @(negedge clk);
        plane_mask = m; group_sel = g; page_row = pr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (bi < total) begin
            s_valid = (cyc % 5) != 2;
            s_data  = dbyte(bi);
            if (poke && bi == PAGE + 3) begin
                start = 1'b1; plane_mask = 4'b0110;   // R8: ignored mid-run
            end else start = 1'b0;
            if (s_valid && s_ready) bi++;
            cyc++;
            @(negedge clk);
        end
        s_valid = 1'b0; start = 1'b0; plane_mask = m;
        while (!done) @(negedge clk);
        check(!err, "R7 err low on success", err, 0);
        check(fail_vec == (pat[4:1] & m), "R7 masked fail_vec", fail_vec, pat[4:1] & m);
        check(fail_any == pat[0], "R7 fail_any", fail_any, pat[0]);
        check(expq.size() == 0, "R3/R5 all transfers seen", expq.size(), 0);
        check(busy_polls > polls0, "R6 polled while busy", busy_polls - polls0, 1);
        @(negedge clk);
        check(!done, "R7 done one cycle", done, 0);
        check(!s_ready, "R4 s_ready low when idle", s_ready, 0);
    endtask

    task automatic refuse(input logic [3:0] m, input logic alt, input string req);
        @(negedge clk);
        plane_mask = m; alt_ptr = alt; start = 1'b1;
        @(negedge clk);
        start = 1'b0; alt_ptr = 1'b0;
        check(done && err, req, {done, err}, 3);
        check(!bus_valid, req, bus_valid, 0);
        @(negedge clk);
        check(!done && !bus_valid, req, {done, bus_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !err && !bus_valid && !s_ready, "reset state",
              {done, err, bus_valid, s_ready}, 0);
        refuse(4'b0000, 1'b0, "R1 zero mask refused");
        refuse(4'b1011, 1'b1, "R2 alternate pointer refused");
        seed = 8'h11; run_op(4'b1111, 1'b0, 13'h0ABC, 5'b01011, 1'b0);
        seed = 8'h52; run_op(4'b1010, 1'b1, 13'h1F01, 5'b11111, 1'b0);
        seed = 8'h93; run_op(4'b0100, 1'b0, 13'h0003, 5'b00000, 1'b0);
        seed = 8'hC4; run_op(4'b1001, 1'b1, 13'h1234, 5'b10000, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule